// File: doc/BRIEF.md
# Strobe-to-Clock Write Leveling Delay Search

This block sits on the controller side of a DDR memory interface and calibrates the write strobe delay for one byte lane. When leveling is required, it starts at delay tap zero and raises the tap one step at a time. At each tap it requests a single strobe pulse. While leveling, the memory device samples its own clock on the rising edge of that strobe and returns the sampled level on a data line. The block waits a programmable settle time and then reads that returned bit. The search stops at the first tap where the returned level is 1 and the level at the tap before was 0. That tap is kept as the calibrated delay.

If the clock is already high at tap zero, the search first moves forward through the high region until it sees a low sample. Only after that does it look for the rising transition. If no transition appears by the last tap, the block reports failure and parks the delay at zero. A system whose strobe-to-clock skew is already within limits can set the bypass input. The block then reports completion at once with a parameterised default tap and sends no strobe pulse.

The delay line, the mode-register writes that put the device into leveling mode, and all analog timing live outside this block.

Top module: `wl_level_search`

## Requirements
- R1: While reset is asserted, and until the first start, tap_o is 0 and strobe_o, done_o and fail_o are all low.
- R2: A start with bypass_i low, given while idle, clears done_o and fail_o and sets tap_o to 0 on the next clock edge. From that edge strobe_o is high for exactly one cycle for each tap that is tried. The pulse is issued in the cycle after the tap value has been applied.
- R3: fb_i passes through a two-flop synchronizer. Each tap step lasts settle_i+2 cycles, so a run that tries n taps reaches done_o or fail_o n*(settle_i+2) cycles after the start edge. settle_i must be at least 1.
- R4: During a search, tap_o only ever stays the same or rises by exactly 1. One strobe pulse is issued per tap tried.
- R5: The search ends at the first tap t where the feedback at t is 1 and the feedback at t-1 is 0. At that point tap_o holds t and done_o goes high.
- R6: If the feedback is 1 at tap 0, the taps that read 1 before the first 0 are stepped over. The result is the first later tap that reads 1 directly after a 0.
- R7: If the last tap (2^TAP_W-1) is reached without a 0-to-1 transition, fail_o goes high and tap_o returns to 0. This happens after all 2^TAP_W taps have been pulsed.
- R8: A start with bypass_i high, given while idle, sets done_o, clears fail_o and loads tap_o with DEFAULT_TAP on the next edge, with no strobe pulse.
- R9: start_i and bypass_i are ignored while a search is in progress. The search result is unchanged.
- R10: done_o and fail_o are never high together. Once set, they and tap_o hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a search (or a bypass) when idle |
| bypass_i | input | 1 | With start_i: skip the search and load the default tap |
| settle_i | input | SETTLE_W | Extra cycles waited after each strobe pulse before sampling |
| fb_i | input | 1 | Asynchronous feedback bit returned by the device on its data line |
| tap_o | output | TAP_W | Strobe delay tap setting |
| strobe_o | output | 1 | One-cycle strobe pulse request |
| done_o | output | 1 | Calibration complete (found or bypassed) |
| fail_o | output | 1 | No rising transition found over the full tap range |

## Verification
The device is modelled as a feedback bit pattern indexed by the current tap. The patterns are swept over the following families, with the settle time rotated through several values:
- Low-then-high patterns with every edge position separate the plain search from an off-by-one in the latched tap.
- Patterns with a leading high run of one to three taps test the forward skip over an initial high region.
- Patterns with no rising transition, including all-high, all-low and high-then-low, test the failure path.
- Pseudo-random patterns test that the search stops at the first rising transition and not at a later one.

Run length and strobe pulse count are compared against the tap count computed in the bench. These two checks reveal a wrong synchronizer depth or a wrong settle count. Bypass starts, both from idle and in the middle of a search, separate the default-tap path from the ignore-while-busy rule.

// File: rtl/wl_pkg.sv
package wl_pkg;

  typedef enum logic [1:0] {
    WL_IDLE   = 2'd0,
    WL_PULSE  = 2'd1,
    WL_SETTLE = 2'd2
  } wl_state_e;

  typedef enum logic [1:0] {
    FB_STEP = 2'd0,
    FB_HIT  = 2'd1
  } fb_verdict_e;

endpackage

// File: rtl/wl_rst_sync.sv
module wl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wl_fb_sync.sv
module wl_fb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/wl_settle_timer.sv
module wl_settle_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = len_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/wl_rise_judge.sv
module wl_rise_judge
  import wl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        eval_i,
  input  logic        fb_i,
  output fb_verdict_e verdict_o
);
  logic seen_low_q, seen_low_d, seen_en;

  always_comb begin
    seen_en    = 1'b0;
    seen_low_d = seen_low_q;
    if (clear_i) begin
      seen_en    = 1'b1;
      seen_low_d = 1'b0;
    end else if (eval_i && !fb_i) begin
      seen_en    = 1'b1;
      seen_low_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_low_q <= 1'b0;
    else if (seen_en) seen_low_q <= seen_low_d;
  end

  assign verdict_o = (fb_i && seen_low_q) ? FB_HIT : FB_STEP;
endmodule

// File: rtl/wl_level_search.sv
module wl_level_search
  import wl_pkg::*;
#(
  parameter int unsigned TAP_W       = 5,
  parameter int unsigned SETTLE_W    = 6,
  parameter int unsigned DEFAULT_TAP = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                bypass_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                fb_i,
  output logic [TAP_W-1:0]    tap_o,
  output logic                strobe_o,
  output logic                done_o,
  output logic                fail_o
);
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};
  localparam logic [TAP_W-1:0] TAP_DEF = TAP_W'(DEFAULT_TAP);

  logic        rst_sync_n;
  logic        fb_sync;
  logic        settle_expired;
  logic        busy;
  logic        accept_search;
  logic        eval_now;
  fb_verdict_e verdict;

  wl_state_e        state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic             done_q, done_d;
  logic             fail_q, fail_d;
  logic             reg_en;

  wl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wl_fb_sync #(.STAGES(2)) u_fb_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (fb_i),
    .q_o   (fb_sync)
  );

  wl_settle_timer #(.CNT_W(SETTLE_W)) u_settle (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (state_q == WL_PULSE),
    .len_i     (settle_i),
    .run_i     (state_q == WL_SETTLE),
    .expired_o (settle_expired)
  );

  wl_rise_judge u_judge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear_i   (accept_search),
    .eval_i    (eval_now),
    .fb_i      (fb_sync),
    .verdict_o (verdict)
  );

  assign busy          = (state_q != WL_IDLE);
  assign accept_search = (state_q == WL_IDLE) && start_i && !bypass_i;
  assign eval_now      = (state_q == WL_SETTLE) && settle_expired;

  // next-state process
  always_comb begin
    state_d = state_q;
    tap_d   = tap_q;
    done_d  = done_q;
    fail_d  = fail_q;
    reg_en  = 1'b0;
    unique case (state_q)
      WL_IDLE: begin
        if (start_i) begin
          reg_en = 1'b1;
          fail_d = 1'b0;
          if (bypass_i) begin
            tap_d  = TAP_DEF;
            done_d = 1'b1;
          end else begin
            tap_d   = '0;
            done_d  = 1'b0;
            state_d = WL_PULSE;
          end
        end
      end
      WL_PULSE: begin
        reg_en  = 1'b1;
        state_d = WL_SETTLE;
      end
      WL_SETTLE: begin
        if (settle_expired) begin
          reg_en = 1'b1;
          if (verdict == FB_HIT) begin
            done_d  = 1'b1;
            state_d = WL_IDLE;
          end else if (tap_q == TAP_MAX) begin
            fail_d  = 1'b1;
            tap_d   = '0;
            state_d = WL_IDLE;
          end else begin
            tap_d   = tap_q + 1'b1;
            state_d = WL_PULSE;
          end
        end
      end
      default: begin
        reg_en  = 1'b1;
        state_d = WL_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= WL_IDLE;
      tap_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else if (reg_en) begin
      state_q <= state_d;
      tap_q   <= tap_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign tap_o    = tap_q;
  assign strobe_o = (state_q == WL_PULSE);
  assign done_o   = done_q;
  assign fail_o   = fail_q;
endmodule

// File: rtl/wl_level_search_chk.sv
module wl_level_search_chk #(
  parameter int unsigned TAP_W       = 5,
  parameter int unsigned DEFAULT_TAP = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             bypass_i,
  input logic             busy,
  input logic [TAP_W-1:0] tap_o,
  input logic             strobe_o,
  input logic             done_o,
  input logic             fail_o
);
  localparam logic [TAP_W-1:0] TAP_DEF = TAP_W'(DEFAULT_TAP);

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

  // R2
  strobe_status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> (busy && !done_o && !fail_o));

  // R4
  tap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      ((tap_o == $past(tap_o)) || (tap_o == TAP_W'($past(tap_o) + 1'b1))));

  // R7
  fail_tap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (tap_o == '0));

  // R8
  bypass_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i && bypass_i) |=> (done_o && !fail_o && !busy && (tap_o == TAP_DEF)));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> (busy || done_o || fail_o));

  // R10
  status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i && $past(!busy)) |=>
      ($stable(done_o) && $stable(fail_o) && $stable(tap_o)));
endmodule

bind wl_level_search wl_level_search_chk #(
  .TAP_W       (TAP_W),
  .DEFAULT_TAP (DEFAULT_TAP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start_i  (start_i),
  .bypass_i (bypass_i),
  .busy     (busy),
  .tap_o    (tap_o),
  .strobe_o (strobe_o),
  .done_o   (done_o),
  .fail_o   (fail_o)
);

// File: tb/tb_wl_level_search.sv
`timescale 1ns/1ps
module tb_wl_level_search;
  localparam int TAP_W    = 4;
  localparam int SETTLE_W = 4;
  localparam int DEF_TAP  = 5;
  localparam int NT       = 1 << TAP_W;

  logic                clk;
  logic                rst_n;
  logic                start_i;
  logic                bypass_i;
  logic [SETTLE_W-1:0] settle_i;
  logic                fb_i;
  logic [TAP_W-1:0]    tap_o;
  logic                strobe_o;
  logic                done_o;
  logic                fail_o;

  logic [NT-1:0] pat;
  int checks;
  int fails;
  int pulses;

  wl_level_search #(
    .TAP_W       (TAP_W),
    .SETTLE_W    (SETTLE_W),
    .DEFAULT_TAP (DEF_TAP)
  ) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .bypass_i (bypass_i),
    .settle_i (settle_i),
    .fb_i     (fb_i),
    .tap_o    (tap_o),
    .strobe_o (strobe_o),
    .done_o   (done_o),
    .fail_o   (fail_o)
  );

  // device model: returned clock level depends on the current tap
  assign fb_i = pat[tap_o];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (strobe_o) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_hit(input logic [NT-1:0] p);
    bit seen = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (!p[t]) seen = 1'b1;
      else if (seen) return t;
    end
    return -1;
  endfunction

  task automatic run_search(input logic [NT-1:0] p, input int s, input bit interrupt,
                            input bit hold_check);
    int cyc;
    int hit;
    int n;
    string tag;
    hit = ref_hit(p);
    n   = (hit >= 0) ? hit + 1 : NT;
    tag = (hit < 0) ? "R7" : (p[0] ? "R6" : "R5");
    @(negedge clk);
    pat = p; settle_i = SETTLE_W'(s); bypass_i = 1'b0; start_i = 1'b1; pulses = 0;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    // R2: first strobe pulse with tap 0 and status cleared
    chk("R2 strobe", int'(strobe_o), 1);
    chk("R2 tap0", int'(tap_o), 0);
    while (!(done_o || fail_o)) begin
      if (interrupt && cyc == 6) begin start_i = 1'b1; bypass_i = 1'b1; end
      else begin start_i = 1'b0; bypass_i = 1'b0; end
      @(negedge clk);
      cyc++;
      if (cyc > 4000) break;
    end
    start_i = 1'b0; bypass_i = 1'b0;
    if (cyc > 4000) begin
      fails++; checks++;
      $display("FAIL R3 run hung actual=%0d expected=%0d", cyc, n * (s + 2) + 1);
      return;
    end
    chk({tag, " tap"}, int'(tap_o), (hit >= 0) ? hit : 0);
    chk({tag, " done"}, int'(done_o), (hit >= 0) ? 1 : 0);
    chk({tag, " fail"}, int'(fail_o), (hit >= 0) ? 0 : 1);
    chk("R4 pulse count", pulses, n);
    chk("R3 run length", cyc, n * (s + 2) + 1);
    if (interrupt) chk("R9 tap after mid-run start", int'(tap_o), (hit >= 0) ? hit : 0);
    if (hold_check) begin
      repeat (3) @(negedge clk);
      chk("R10 tap hold", int'(tap_o), (hit >= 0) ? hit : 0);
      chk("R10 status hold", int'({done_o, fail_o}), (hit >= 0) ? 2 : 1);
    end
  endtask

  task automatic run_bypass();
    @(negedge clk);
    start_i = 1'b1; bypass_i = 1'b1; pulses = 0;
    @(negedge clk);
    start_i = 1'b0; bypass_i = 1'b0;
    chk("R8 tap default", int'(tap_o), DEF_TAP);
    chk("R8 done", int'(done_o), 1);
    chk("R8 fail", int'(fail_o), 0);
    repeat (2) @(negedge clk);
    chk("R8 no strobe", pulses, 0);
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [NT-1:0] lfsr;
    logic [NT-1:0] p;
    int idx;
    int svals[3];
    checks = 0; fails = 0; pulses = 0;
    svals[0] = 1; svals[1] = 2; svals[2] = 4;
    rst_n = 1'b0; start_i = 1'b0; bypass_i = 1'b0; settle_i = '0; pat = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tap", int'(tap_o), 0);
    chk("R1 strobe", int'(strobe_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 fail", int'(fail_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", int'({strobe_o, done_o, fail_o}), 0);

    run_bypass();

    // structured sweep: ones below h, zeros in [h,k), ones from k
    idx = 0;
    for (int h = 0; h < 4; h++) begin
      for (int k = h; k <= NT; k++) begin
        p = '0;
        for (int t = 0; t < NT; t++) p[t] = (t < h) || (t >= k);
        run_search(p, svals[idx % 3], (idx % 5) == 0, (idx % 7) == 0);
        idx++;
      end
    end
    // high then low only, no rising edge (R7)
    run_search({{(NT/2){1'b0}}, {(NT/2){1'b1}}}, 2, 1'b0, 1'b1);
    run_bypass();

    // pseudo-random patterns
    lfsr = 16'hACE1;
    for (int r = 0; r < 120; r++) begin
      lfsr = {lfsr[NT-2:0], lfsr[NT-1] ^ lfsr[NT-3] ^ lfsr[NT-4] ^ lfsr[NT-6]};
      run_search(lfsr, svals[r % 3], (r % 9) == 4, (r % 11) == 0);
    end
    run_bypass();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule